// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block is a bus-slave register pair through which firmware pulls small read-only byte blobs, each named by a 16-bit key. A write to the selector register chooses an item and rewinds that item's read cursor. Each read of the data register then returns the next bytes of the item and moves the cursor forward by the access width. One data read can therefore return one byte or a whole 8-byte word.

The item store is a computed ROM. It holds a 4-byte presence signature at key 0x0000 and a 32-bit feature bitmap at key 0x0001. It also holds a parameterized run of generic file items starting at key `FILE_BASE`, and one architecture-specific item at key 0x8000. Bytes come back in string order: the item byte at the cursor lands in the lowest byte lane of the access. Bus bridging and any parsing of item contents happen outside the block.

Top module: `kcfg_port`

## Requirements
- R1: After reset the selected key is 0x0000 and the cursor is 0, so the first data read returns the start of the signature item.
- R2: A write to address 8 (selector) takes key = wdata[15:0] and sets the cursor to 0.
- R3: Key bit 14 is ignored when choosing an item, so keys k|0x4000 and k select the same item.
- R4: Key bit 15 selects the architecture-specific space. Key 0x8000 is an item of ARCH_LEN bytes whose byte at offset o is 0xA0+o.
- R5: A data read at address 0 with reqSize s returns N = 1<<s bytes. Lane k (bits 8k+7:8k) holds the item byte at cursor+k, lanes k >= N are zero, and the cursor advances by N.
- R6: Item bytes at or beyond the item length read as zero, and the cursor never passes the item length (it clamps and does not wrap).
- R7: A key with no item behaves as a zero-length item: every lane reads zero.
- R8: Key 0x0000 is a 4-byte item. Its offset 0 holds SIGNATURE[31:24], down to offset 3, which holds SIGNATURE[7:0].
- R9: Key 0x0001 is a 4-byte little-endian bitmap. Bit 0 is always 1, bit 1 equals DMA_PRESENT, and all other bits are 0.
- R10: Key FILE_BASE+i, for i < NUM_FILES, is an item of FILE_LEN_BASE + FILE_LEN_STEP*i bytes. Its byte at offset o is (0x5A + 16*i + 7*o) mod 256.
- R11: Writes to the data register change neither the key nor the cursor.
- R12: Every read gets rspValid exactly one cycle after the request. Reads at any address other than 0 return zero and leave the cursor alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Bus access this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte offset: 0 data, 8 selector |
| reqSize | input | 2 | Access width as log2 of byte count |
| reqWdata | input | 64 | Write data (selector key in bits 15:0) |
| rspValid | output | 1 | Read response valid, one cycle after a read |
| rspData | output | 64 | Read data, string-ordered byte lanes |

## Verification
The assertions assume that reqValid is low during reset. They also assume that a request is a single-cycle pulse, so that each read strobe maps to exactly one response on the following cycle. The stimulus drives every access as a one-cycle pulse away from the clock edge. Its keys come from a mix of real items, their bit-14 aliases and unused keys, with random read widths, so reads often run past the end of an item. Occasional data writes and reads of the selector and spare addresses are interleaved.

// File: rtl/kcfg_pkg.sv
package kcfg_pkg;
  localparam int LANES = 8;
  localparam int DATA_W = 8 * LANES;
  localparam int KEY_W = 16;

  typedef struct packed {
    logic             selWrite;
    logic             dataRead;
    logic             dataWrite;
    logic             otherRead;
    logic [1:0]       size;
    logic [KEY_W-1:0] newKey;
  } strobe_t;
endpackage

// File: rtl/kcfg_ctrl.sv
module kcfg_ctrl
  import kcfg_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_OFF = 0,
  parameter int SEL_OFF  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  output strobe_t           strobe
);
  logic hitData;
  logic hitSel;
  logic unusedHigh;

  assign hitData = (reqAddr == ADDR_W'(DATA_OFF));
  assign hitSel  = (reqAddr == ADDR_W'(SEL_OFF));
  assign unusedHigh = ^reqWdata[DATA_W-1:KEY_W];

  always_comb begin
    strobe = '0;
    strobe.size   = reqSize;
    strobe.newKey = reqWdata[KEY_W-1:0];
    if (reqValid) begin
      strobe.selWrite  = reqWrite && hitSel;
      strobe.dataWrite = reqWrite && hitData;
      strobe.dataRead  = !reqWrite && hitData;
      strobe.otherRead = !reqWrite && !hitData;
    end
  end

  // R12: at most one action per access
  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.selWrite, strobe.dataWrite, strobe.dataRead, strobe.otherRead}));

  // R2: an idle bus cycle produces no action
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !reqValid |-> !(strobe.selWrite || strobe.dataWrite || strobe.dataRead || strobe.otherRead));
endmodule

// File: rtl/kcfg_datapath.sv
module kcfg_datapath
  import kcfg_pkg::*;
#(
  parameter logic [31:0] SIGNATURE     = 32'h4B49_5250,
  parameter bit          DMA_PRESENT   = 1'b0,
  parameter int          NUM_FILES     = 3,
  parameter int          FILE_BASE     = 32,
  parameter int          FILE_LEN_BASE = 5,
  parameter int          FILE_LEN_STEP = 3,
  parameter int          ARCH_LEN      = 6,
  parameter int          OFF_W         = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  localparam int IDX_W = KEY_W - 2;

  logic [KEY_W-1:0] curKey;
  logic [OFF_W-1:0] curOff;
  logic [OFF_W-1:0] curLen;
  logic [3:0]       accBytes;
  logic [OFF_W:0]   advOff;
  logic [OFF_W-1:0] nextOff;
  logic [7:0]       laneByte [LANES];
  logic [DATA_W-1:0] packed_;

  function automatic logic [OFF_W-1:0] itemLen(input logic [KEY_W-1:0] key);
    logic [IDX_W-1:0] idx;
    int fileNo;
    idx = key[IDX_W-1:0];
    fileNo = int'(idx) - FILE_BASE;
    if (key[KEY_W-1]) begin
      itemLen = (idx == '0) ? OFF_W'(ARCH_LEN) : '0;
    end else if (idx == IDX_W'(0) || idx == IDX_W'(1)) begin
      itemLen = OFF_W'(4);
    end else if (fileNo >= 0 && fileNo < NUM_FILES) begin
      itemLen = OFF_W'(FILE_LEN_BASE + FILE_LEN_STEP * fileNo);
    end else begin
      itemLen = '0;
    end
  endfunction

  function automatic logic [7:0] itemByte(input logic [KEY_W-1:0] key,
                                          input logic [OFF_W:0]   off);
    logic [IDX_W-1:0] idx;
    int fileNo;
    logic [31:0] feat;
    idx = key[IDX_W-1:0];
    fileNo = int'(idx) - FILE_BASE;
    feat = {30'd0, DMA_PRESENT, 1'b1};
    itemByte = 8'h00;
    if (key[KEY_W-1]) begin
      itemByte = 8'(32'hA0 + 32'(off));
    end else if (idx == IDX_W'(0)) begin
      case (off[1:0])
        2'd0: itemByte = SIGNATURE[31:24];
        2'd1: itemByte = SIGNATURE[23:16];
        2'd2: itemByte = SIGNATURE[15:8];
        default: itemByte = SIGNATURE[7:0];
      endcase
    end else if (idx == IDX_W'(1)) begin
      itemByte = feat[8*off[1:0] +: 8];
    end else begin
      itemByte = 8'(32'h5A + 32'(fileNo) * 16 + 32'(off) * 7);
    end
  endfunction

  assign curLen   = itemLen(curKey);
  assign accBytes = 4'd1 << strobe.size;
  assign advOff   = {1'b0, curOff} + (OFF_W+1)'(accBytes);
  assign nextOff  = (advOff > {1'b0, curLen}) ? curLen : advOff[OFF_W-1:0];

  for (genvar k = 0; k < LANES; k++) begin : gLane
    logic [OFF_W:0] pos;
    assign pos = {1'b0, curOff} + (OFF_W+1)'(k);
    assign laneByte[k] = (4'(k) < accBytes && pos < {1'b0, curLen})
                         ? itemByte(curKey, pos) : 8'h00;
    assign packed_[8*k +: 8] = laneByte[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curKey   <= '0;
      curOff   <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.dataRead || strobe.otherRead;
      rspData  <= strobe.dataRead ? packed_ : '0;
      if (strobe.selWrite) begin
        curKey <= strobe.newKey;
        curOff <= '0;
      end else if (strobe.dataRead) begin
        curOff <= nextOff;
      end
    end
  end

  // R6: the cursor never passes the end of the selected item
  assert_offset_bound_R6: assert property (@(posedge clk) disable iff (rst)
    curOff <= curLen);

  // R2: a selector write loads the key and rewinds the cursor
  assert_sel_resets_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.selWrite |=> (curOff == '0) && (curKey == $past(strobe.newKey)));

  // R11: data writes leave key and cursor untouched
  assert_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    strobe.dataWrite |=> $stable(curOff) && $stable(curKey));

  // R12: a response follows every read, and only reads
  assert_resp_follows_R12: assert property (@(posedge clk) disable iff (rst)
    (strobe.dataRead || strobe.otherRead) |=> rspValid);
  assert_no_spurious_R12: assert property (@(posedge clk) disable iff (rst)
    !(strobe.dataRead || strobe.otherRead) |=> !rspValid);

  // R12: reads away from the data register return zero
  assert_other_zero_R12: assert property (@(posedge clk) disable iff (rst)
    strobe.otherRead |=> rspData == '0);
endmodule

// File: rtl/kcfg_port.sv
module kcfg_port
  import kcfg_pkg::*;
#(
  parameter logic [31:0] SIGNATURE     = 32'h4B49_5250,
  parameter bit          DMA_PRESENT   = 1'b0,
  parameter int          NUM_FILES     = 3,
  parameter int          FILE_BASE     = 32,
  parameter int          FILE_LEN_BASE = 5,
  parameter int          FILE_LEN_STEP = 3,
  parameter int          ARCH_LEN      = 6,
  parameter int          OFF_W         = 16,
  parameter int          ADDR_W        = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [63:0]       reqWdata,
  output logic              rspValid,
  output logic [63:0]       rspData
);
  strobe_t strobe;

  kcfg_ctrl #(.ADDR_W(ADDR_W), .DATA_OFF(0), .SEL_OFF(8)) uCtrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata), .strobe(strobe)
  );

  kcfg_datapath #(
    .SIGNATURE(SIGNATURE), .DMA_PRESENT(DMA_PRESENT), .NUM_FILES(NUM_FILES),
    .FILE_BASE(FILE_BASE), .FILE_LEN_BASE(FILE_LEN_BASE),
    .FILE_LEN_STEP(FILE_LEN_STEP), .ARCH_LEN(ARCH_LEN), .OFF_W(OFF_W)
  ) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .rspValid(rspValid), .rspData(rspData)
  );
endmodule

// File: tb/kcfg_port_test.sv
module kcfg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SIG = 32'h4B49_5250;
  localparam bit DMA = 1'b0;
  localparam int NFILES = 3;
  localparam int FBASE = 32;
  localparam int FLEN0 = 5;
  localparam int FSTEP = 3;
  localparam int ALEN = 6;

  logic clk = 0;
  logic rst = 1;
  logic reqValid = 0;
  logic reqWrite = 0;
  logic [4:0] reqAddr = 0;
  logic [1:0] reqSize = 0;
  logic [63:0] reqWdata = 0;
  logic rspValid;
  logic [63:0] rspData;

  int checks = 0;
  int errors = 0;
  int expKey = 0;
  int expOff = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kcfg_port #(.SIGNATURE(SIG), .DMA_PRESENT(DMA), .NUM_FILES(NFILES),
    .FILE_BASE(FBASE), .FILE_LEN_BASE(FLEN0), .FILE_LEN_STEP(FSTEP),
    .ARCH_LEN(ALEN), .OFF_W(16), .ADDR_W(5)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData));

  function automatic int expLen(int key);
    int idx = key & 16'h3FFF;
    if ((key & 16'h8000) != 0) return (idx == 0) ? ALEN : 0;
    if (idx == 0 || idx == 1) return 4;
    if (idx >= FBASE && idx < FBASE + NFILES) return FLEN0 + FSTEP * (idx - FBASE);
    return 0;
  endfunction

  function automatic logic [7:0] expByte(int key, int off);
    int idx = key & 16'h3FFF;
    if (off >= expLen(key)) return 8'h00;
    if ((key & 16'h8000) != 0) return 8'((32'hA0 + off) & 255);           // R4
    if (idx == 0) return SIG[8*(3-off) +: 8];                              // R8
    if (idx == 1) return (off == 0) ? {6'd0, DMA, 1'b1} : 8'h00;           // R9
    return 8'((32'h5A + 16*(idx - FBASE) + 7*off) & 255);                  // R10
  endfunction

  function automatic logic [63:0] expRead(int key, int off, int size);
    logic [63:0] v = '0;
    int n = 1 << size;
    for (int k = 0; k < n; k++) v[8*k +: 8] = expByte(key, off + k);
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [4:0] addr, logic [1:0] sz, logic [63:0] wd);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = addr; reqSize = sz; reqWdata = wd;
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
  endtask

  task automatic selKey(int key);
    access(1, 5'd8, 2'd1, {48'hDEAD_BEEF_0000, 16'(key)});
    expKey = key & 16'hFFFF;
    expOff = 0;
  endtask

  task automatic readData(int sz, string req);
    logic [63:0] e;
    int len;
    e = expRead(expKey, expOff, sz);
    access(0, 5'd0, 2'(sz), 64'd0);
    check(rspValid === 1'b1, "R12", {63'd0, rspValid}, 64'd1);
    check(rspData === e, req, rspData, e);
    len = expLen(expKey);
    expOff = (expOff + (1 << sz) > len) ? len : expOff + (1 << sz);
  endtask

  task automatic readOther(logic [4:0] addr);
    access(0, addr, 2'd3, 64'd0);
    check(rspValid === 1'b1 && rspData === 64'd0, "R12", rspData, 64'd0);
  endtask

  function automatic int pickKey(int r);
    case (r % 12)
      0: return 16'h0000; 1: return 16'h0001; 2: return 16'h4001;
      3: return 16'h8000; 4: return 16'hC000; 5: return 16'h0020;
      6: return 16'h0021; 7: return 16'h0022; 8: return 16'h4021;
      9: return 16'h0005; 10: return 16'h8003;
      default: return int'($urandom) & 16'hFFFF;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(rspValid === 1'b0 && rspData === 64'd0, "R1", rspData, 64'd0);
    rst = 0;
    // R1 / R8: signature readable right after reset
    readData(2, "R1");
    readData(0, "R6");   // past end: zero, no wrap
    // R9 feature bitmap, R3 alias through bit 14
    selKey(16'h0001); readData(3, "R9");
    selKey(16'h4001); readData(2, "R3");
    // R4 architecture space vs generic
    selKey(16'h8000); readData(3, "R4");
    selKey(16'hC000); readData(1, "R3");
    // R10 file item in single bytes then a wide read crossing the end
    selKey(16'h0021); readData(0, "R10"); readData(0, "R10"); readData(3, "R6"); readData(3, "R6");
    // R7 unknown key
    selKey(16'h0077); readData(3, "R7");
    // R11 data write ignored, R12 other reads
    selKey(16'h0022); readData(1, "R5");
    access(1, 5'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    readData(1, "R11");
    readOther(5'd8); readOther(5'd16);
    readData(2, "R12");
    // R2 reselect rewinds
    selKey(16'h0022); readData(3, "R2");
    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom % 10);
      if (op < 2) selKey(pickKey(int'($urandom)));
      else if (op < 8) readData(int'($urandom % 4), "R5");
      else if (op == 8) begin
        access(1, 5'd0, 2'(int'($urandom % 4)), {$urandom, $urandom});
        readData(0, "R11");
      end else readOther(5'(8 + 8 * int'($urandom % 3)));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule